// File: doc/BRIEF.md
# Multi-Format Conversion Result Table

This block holds sixty-four ten-bit analog conversion results. A converter-side port writes one result per cycle into the slot chosen by the active command entry. Slot N always holds the result of command slot N. A 16-bit register-bus slave port reads and writes the same storage.

The bus sees the table through three address windows of 64 halfwords each. Each window returns the stored value in its own alignment:

- right-justified unsigned;
- left-justified with the top bit inverted, so that half-scale offset-binary becomes two's complement;
- left-justified unsigned.

Bus writes go through any window and always take the value from the low ten data bits. Read data is registered and arrives one cycle after the request. The asynchronous active-low reset is released synchronously inside the block.

Top module: `conv_result_table`

## Requirements
- R1: After reset, every slot holds zero, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R2: A converter write (`cv_wr_en`=1) stores `cv_wr_data` into the slot `cv_wr_idx` at the clock edge, and leaves other slots unchanged.
- R3: A read at byte address 0x080+2N returns {6'b0, slot N}: the result in bits [9:0] and zeros in bits [15:10].
- R4: A read at 0x100+2N returns {~slot[9], slot[8:0], 6'b0}: the result in bits [15:6] with its top bit inverted, and zeros in bits [5:0].
- R5: A read at 0x180+2N returns {slot N, 6'b0}: the result unmodified in bits [15:6], and zeros in bits [5:0].
- R6: A bus write (`bus_wr`=1) through any of the three windows stores `bus_wdata[9:0]` into slot N, and `bus_wdata[15:10]` is ignored.
- R7: The slot index is `bus_addr[6:1]`. Address bit 0 has no effect on reads or writes.
- R8: Addresses below 0x080 or at 0x200 and above read as 0x0000 with `bus_rvalid`=1, and writes to them change no slot.
- R9: When a converter write and a bus write hit the same slot in the same cycle, the converter value is stored. When they hit different slots, both values are stored.
- R10: `bus_rvalid` is 1 exactly in the cycle after a cycle with `bus_rd`=1. `bus_rdata` holds its last value while no read is issued. A read in the same cycle as a write to that slot returns the old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_wr_en | input | 1 | Converter result write strobe |
| cv_wr_idx | input | 6 | Command slot index of the result |
| cv_wr_data | input | 10 | Conversion result |
| bus_addr | input | 10 | Bus byte address |
| bus_rd | input | 1 | Bus read request |
| bus_wr | input | 1 | Bus write request |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |

## Verification
A converter or bus write lands at the clock edge where its strobe is sampled. The stored value is therefore visible to a read issued in the next cycle. A read's data and `bus_rvalid` appear after the edge that samples `bus_rd`, one cycle later. The bench drives every input on the falling edge and compares the outputs on the falling edge that follows the capturing rising edge. No check waits a variable time. Collision and read-during-write cases are set up in a single cycle, and each case is then read back with a separate read.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
  localparam int SLOTS  = 64;
  localparam int RES_W  = 10;
  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int PAD_W  = WORD_W - RES_W;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_RJU  = 2'd1,
    VIEW_LJS  = 2'd2,
    VIEW_LJU  = 2'd3
  } view_e;
endpackage

// File: rtl/rtab_decode.sv
module rtab_decode
  import rtab_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output view_e             view,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_LSB = IDX_W + 1;
  localparam int WIN_W   = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] win;
  logic             unused_b0;

  assign win       = addr[ADDR_W-1:WIN_LSB];
  assign idx       = addr[WIN_LSB-1:1];
  assign unused_b0 = addr[0];

  always_comb begin
    case (win)
      WIN_W'(1): view = VIEW_RJU;
      WIN_W'(2): view = VIEW_LJS;
      WIN_W'(3): view = VIEW_LJU;
      default:   view = VIEW_NONE;
    endcase
  end
endmodule

// File: rtl/rtab_format.sv
module rtab_format
  import rtab_pkg::*;
(
  input  view_e             view,
  input  logic [RES_W-1:0]  slot,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    case (view)
      VIEW_RJU: word = {{PAD_W{1'b0}}, slot};
      VIEW_LJS: word = {~slot[RES_W-1], slot[RES_W-2:0], {PAD_W{1'b0}}};
      VIEW_LJU: word = {slot, {PAD_W{1'b0}}};
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/rtab_store.sv
module rtab_store
  import rtab_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cv_we,
  input  logic [IDX_W-1:0] cv_idx,
  input  logic [RES_W-1:0] cv_data,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [RES_W-1:0] bus_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] slot_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic             cv_hit, bus_hit, en;
    logic [RES_W-1:0] d;

    always_comb begin
      cv_hit  = cv_we  && (cv_idx  == IDX_W'(i));
      bus_hit = bus_we && (bus_idx == IDX_W'(i));
      en      = cv_hit || bus_hit;
      d       = cv_hit ? cv_data : bus_data;   // converter has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= '0;
      else if (en) slot_q[i] <= d;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/conv_result_table.sv
module conv_result_table
  import rtab_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_wr_en,
  input  logic [5:0]        cv_wr_idx,
  input  logic [9:0]        cv_wr_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  view_e             view;
  logic [IDX_W-1:0]  idx;
  logic [RES_W-1:0]  slot_rd;
  logic [WORD_W-1:0] fmt_word;
  logic              bus_we;
  logic [WORD_W-1:0] rdata_nx, rdata_q;
  logic              rvalid_nx, rvalid_q;
  logic              unused_hi;

  // Reset: asserts at once, releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtab_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .view(view), .idx(idx)
  );

  assign bus_we    = bus_wr && (view != VIEW_NONE);
  assign unused_hi = ^bus_wdata[WORD_W-1:RES_W];

  rtab_store u_store (
    .clk(clk), .rst_n(rst_int_n),
    .cv_we(cv_wr_en), .cv_idx(cv_wr_idx), .cv_data(cv_wr_data),
    .bus_we(bus_we), .bus_idx(idx), .bus_data(bus_wdata[RES_W-1:0]),
    .rd_idx(idx), .rd_data(slot_rd)
  );

  rtab_format u_fmt (.view(view), .slot(slot_rd), .word(fmt_word));

  always_comb begin
    rvalid_nx = bus_rd;
    rdata_nx  = bus_rd ? fmt_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_nx;
      rvalid_q <= rvalid_nx;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/conv_result_table_chk.sv
module conv_result_table_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [15:0]       bus_rdata,
  input logic              bus_rvalid
);
  logic [ADDR_W-8:0] win;
  assign win = bus_addr[ADDR_W-1:7];

  p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bus_rd |=> bus_rvalid);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !bus_rd |=> !bus_rvalid);
  p_rdata_holds_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !bus_rd |=> $stable(bus_rdata));
  p_rj_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_rd && win == 1) |=> (bus_rdata[15:10] == 6'd0));
  p_lj_lower_zero_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_rd && (win == 2 || win == 3)) |=> (bus_rdata[5:0] == 6'd0));
  p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (bus_rd && (win == 0 || win > 3)) |=> (bus_rdata == 16'd0));
endmodule

bind conv_result_table conv_result_table_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ok_n(rst_int_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
);

// File: tb/conv_result_table_bench.sv
module conv_result_table_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cv_wr_en;
  logic [5:0]  cv_wr_idx;
  logic [9:0]  cv_wr_data;
  logic [9:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] model [64];

  always #4 clk = ~clk;   // 125 MHz

  conv_result_table u_conv_result_table (
    .clk(clk), .rst_n(rst_n), .cv_wr_en(cv_wr_en), .cv_wr_idx(cv_wr_idx),
    .cv_wr_data(cv_wr_data), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  function automatic logic [9:0] a_rj(int n);  return 10'(12'h080 + 2*n); endfunction
  function automatic logic [9:0] a_ljs(int n); return 10'(12'h100 + 2*n); endfunction
  function automatic logic [9:0] a_lju(int n); return 10'(12'h180 + 2*n); endfunction
  function automatic logic [15:0] f_rj(logic [9:0] v);  return {6'b0, v}; endfunction
  function automatic logic [15:0] f_ljs(logic [9:0] v); return {~v[9], v[8:0], 6'b0}; endfunction
  function automatic logic [15:0] f_lju(logic [9:0] v); return {v, 6'b0}; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cv_wr_en = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic conv_wr(int n, logic [9:0] v);
    cv_wr_en = 1; cv_wr_idx = 6'(n); cv_wr_data = v;
    @(negedge clk); idle();
    model[n] = v;
  endtask

  task automatic bus_write(logic [9:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic bus_read(logic [9:0] a, output logic [15:0] d, output logic v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk); idle();
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic v;
    check("R1 rvalid", 32'(bus_rvalid), 0);
    check("R1 rdata", 32'(bus_rdata), 0);
    for (int n = 0; n < 64; n += 21) begin
      bus_read(a_rj(n), d, v);
      check("R1 slot", 32'(d), 0);
    end
    for (int n = 0; n < 64; n++) model[n] = '0;
  endtask

  task automatic t_conv_write();
    logic [15:0] d; logic v;
    conv_wr(7, 10'h2A5);
    conv_wr(63, 10'h3FF);
    bus_read(a_rj(7), d, v);  check("R2 slot7", 32'(d), 32'(f_rj(10'h2A5)));
    bus_read(a_rj(63), d, v); check("R2 slot63", 32'(d), 32'(f_rj(10'h3FF)));
    bus_read(a_rj(8), d, v);  check("R2 neighbour", 32'(d), 0);
  endtask

  task automatic t_views();
    logic [15:0] d; logic v;
    logic [9:0] pats [5] = '{10'h000, 10'h3FF, 10'h200, 10'h1FF, 10'h155};
    for (int k = 0; k < 5; k++) begin
      conv_wr(10 + k, pats[k]);
      bus_read(a_rj(10 + k), d, v);  check("R3 right unsigned", 32'(d), 32'(f_rj(pats[k])));
      bus_read(a_ljs(10 + k), d, v); check("R4 left signed", 32'(d), 32'(f_ljs(pats[k])));
      bus_read(a_lju(10 + k), d, v); check("R5 left unsigned", 32'(d), 32'(f_lju(pats[k])));
    end
  endtask

  task automatic t_bus_write();
    logic [15:0] d; logic v;
    bus_write(a_rj(20),  16'hFC01); model[20] = 10'h001;
    bus_write(a_ljs(21), 16'hABCD); model[21] = 10'h3CD;
    bus_write(a_lju(22), 16'h8200); model[22] = 10'h200;
    for (int n = 20; n < 23; n++) begin
      bus_read(a_rj(n), d, v);
      check("R6 stored low bits", 32'(d), 32'(f_rj(model[n])));
    end
  endtask

  task automatic t_addr_bit0();
    logic [15:0] d; logic v;
    bus_write(a_rj(30) | 10'd1, 16'h0123); model[30] = 10'h123;
    bus_read(a_rj(30), d, v);         check("R7 write odd addr", 32'(d), 32'(f_rj(10'h123)));
    bus_read(a_lju(30) | 10'd1, d, v); check("R7 read odd addr", 32'(d), 32'(f_lju(10'h123)));
    bus_read(a_rj(31), d, v);          check("R7 neighbour", 32'(d), 32'(f_rj(model[31])));
  endtask

  task automatic t_outside();
    logic [15:0] d; logic v;
    conv_wr(0, 10'h111);
    bus_write(10'h000, 16'h0222);
    bus_write(10'h200, 16'h0333);
    bus_write(10'h07E, 16'h0044);
    bus_read(10'h000, d, v); check("R8 low read data", 32'(d), 0);
    check("R8 low read valid", 32'(v), 1);
    bus_read(10'h27E, d, v); check("R8 high read data", 32'(d), 0);
    bus_read(a_rj(0), d, v);  check("R8 slot0 untouched", 32'(d), 32'(f_rj(10'h111)));
    bus_read(a_rj(63), d, v); check("R8 slot63 untouched", 32'(d), 32'(f_rj(model[63])));
  endtask

  task automatic t_collision();
    logic [15:0] d; logic v;
    cv_wr_en = 1; cv_wr_idx = 6'd40; cv_wr_data = 10'h0AA;
    bus_wr = 1; bus_addr = a_rj(40); bus_wdata = 16'h0155;
    @(negedge clk); idle();
    bus_read(a_rj(40), d, v); check("R9 converter wins", 32'(d), 32'(f_rj(10'h0AA)));
    cv_wr_en = 1; cv_wr_idx = 6'd41; cv_wr_data = 10'h0F0;
    bus_wr = 1; bus_addr = a_ljs(42); bus_wdata = 16'h030F;
    @(negedge clk); idle();
    bus_read(a_rj(41), d, v); check("R9 both conv", 32'(d), 32'(f_rj(10'h0F0)));
    bus_read(a_rj(42), d, v); check("R9 both bus", 32'(d), 32'(f_rj(10'h30F)));
  endtask

  task automatic t_latency();
    logic [15:0] d; logic v;
    conv_wr(50, 10'h2C3);
    bus_read(a_lju(50), d, v);
    check("R10 valid", 32'(v), 1);
    check("R10 data", 32'(d), 32'(f_lju(10'h2C3)));
    @(negedge clk);
    check("R10 valid drops", 32'(bus_rvalid), 0);
    check("R10 data held", 32'(bus_rdata), 32'(f_lju(10'h2C3)));
    cv_wr_en = 1; cv_wr_idx = 6'd50; cv_wr_data = 10'h001;
    bus_rd = 1; bus_addr = a_rj(50);
    @(negedge clk); idle();
    check("R10 read old on write", 32'(bus_rdata), 32'(f_rj(10'h2C3)));
    bus_read(a_rj(50), d, v);
    check("R10 new value next read", 32'(d), 32'(f_rj(10'h001)));
  endtask

  initial begin
    idle();
    cv_wr_idx = '0; cv_wr_data = '0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_conv_write();
    t_views();
    t_bus_write();
    t_addr_bit0();
    t_outside();
    t_collision();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule